// File: doc/BRIEF.md
# Line Diagnostic Filter Engine

This block post-processes the slow monitor samples of a subscriber line. On each valid sample it takes the tip and ring voltages and currents plus two external ringing measurements. It picks one measurement stream, which may be a raw input or a metallic or longitudinal value formed on the fly. It sends that stream to three result units in parallel. The first holds the largest magnitude seen since the last restart. The second is a DC single-pole IIR low-pass filter. The third rectifies the stream to its absolute value and passes it through a second single-pole IIR low-pass filter with its own coefficient.

Software controls the engine through a small register port. One control word carries the enable and the source select. There is a coefficient for each filter. The three results can be read back. A select change, or a rising enable, flushes all three results to zero. Writing zero to the peak register restarts peak tracking, so the peak can be taken over a chosen window. An abort input, driven by hook or ring-trip detection, clears the enable at once, and no further samples are taken.

Top module: `line_diag_engine`

## Requirements
- R1: After reset the enable is 0, the select is 0, both coefficients are 0, and the peak, DC and AC results all read 0.
- R2: Select codes in the control word bits [3:1] pick, in code order 0..7, the following sources. Code 0 is tip voltage and code 1 is ring voltage. Code 2 is tip voltage minus ring voltage, and code 3 is (tip voltage + ring voltage) >>> 1. Codes 4 and 5 are the same two forms built from the tip and ring currents. Code 6 is external ringing voltage and code 7 is external ringing current. The sums and differences are formed one bit wider than the 8-bit two's-complement inputs, so they never overflow.
- R3: On each processed sample the peak result (address 3) becomes the larger of its old value and the absolute value of the selected sample, unsigned. An absolute value that does not fit saturates to the largest positive value.
- R4: On each processed sample the DC result y (address 4, 16-bit signed) becomes y + (((x − y) · k) >>> 15), saturated to 16 bits. Here x is the selected sample, sign-extended. k is the 15-bit unsigned DC coefficient at address 1.
- R5: The AC result (address 5) follows the same update, using the absolute value of the selected sample as x and the AC coefficient at address 2.
- R6: A control write (address 0) that raises the enable from 0 to 1, or that changes the select, clears the peak, DC and AC results in the next cycle. A sample arriving in that cycle is not processed. A control write that keeps both the enable and the select unchanged leaves all results untouched.
- R7: Writing the value 0 to address 3 clears the peak in the next cycle, and that cycle's sample is not added to the peak. Writing a nonzero value to address 3 is ignored.
- R8: While the abort input is high, the enable bit is cleared in the next cycle, even if a control write in the same cycle sets it. A sample arriving with the abort is not processed.
- R9: A sample is processed only in a cycle with the sample-valid strobe high and the enable at 1. In any other cycle without a register write, all three results hold their values.
- R10: Reading address 0 returns {zeros, select[2:0], enable}. Addresses 1 and 2 return the coefficients written there, in bits [14:0]. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe marking a new monitor sample |
| tip_v | input | 8 | Tip voltage sample, signed |
| ring_v | input | 8 | Ring voltage sample, signed |
| tip_i | input | 8 | Tip current sample, signed |
| ring_i | input | 8 | Ring current sample, signed |
| extr_v | input | 8 | External ringing voltage sample, signed |
| extr_i | input | 8 | External ringing current sample, signed |
| hook_abort | input | 1 | Off-hook or ring-trip indication |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 16 | Register read data, combinational from reg_raddr |

## Verification
Several rules are checked on every cycle. An abort always leaves the engine disabled. The peak never shrinks except after a control or peak write. The AC result is never negative. The filters hold still when no sample arrives, and all results hold while the engine is disabled. A select change or a peak-zero write empties the results on the next cycle. The exact filter arithmetic for each source code can only be shown by the bench, which compares every readback against a model over random traffic and directed extremes. The same holds for the floor rounding of the halved longitudinal sums, the ignored nonzero peak write, the same-select rewrite that must not flush, and the sample that coincides with an abort.

// File: rtl/line_diag_pkg.sv
package line_diag_pkg;

   typedef enum logic [2:0] {
      A_CTRL  = 3'd0,
      A_KDC   = 3'd1,
      A_KAC   = 3'd2,
      A_PEAK  = 3'd3,
      A_DCOUT = 3'd4,
      A_ACOUT = 3'd5
   } ldiag_addr_e;

   typedef enum logic [2:0] {
      SRC_TIP_V  = 3'd0,
      SRC_RING_V = 3'd1,
      SRC_LOOP_V = 3'd2,
      SRC_LONG_V = 3'd3,
      SRC_LOOP_I = 3'd4,
      SRC_LONG_I = 3'd5,
      SRC_EXT_V  = 3'd6,
      SRC_EXT_I  = 3'd7
   } ldiag_src_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_SEL_LSB = 1;

endpackage

// File: rtl/ldiag_src_sel.sv
module ldiag_src_sel
   import line_diag_pkg::*;
#(
   parameter int W = 8
) (
   input  ldiag_src_e        sel,
   input  logic [W-1:0]      tip_v,
   input  logic [W-1:0]      ring_v,
   input  logic [W-1:0]      tip_i,
   input  logic [W-1:0]      ring_i,
   input  logic [W-1:0]      extr_v,
   input  logic [W-1:0]      extr_i,
   output logic signed [W:0] x,
   output logic [W-1:0]      xabs
);
   localparam int XW = W + 1;

   logic signed [XW-1:0] tv, rv, ti, ri, ev, ei;
   logic signed [XW-1:0] vsum, isum;
   logic [XW-1:0]        mag;

   assign tv = $signed({tip_v[W-1],  tip_v});
   assign rv = $signed({ring_v[W-1], ring_v});
   assign ti = $signed({tip_i[W-1],  tip_i});
   assign ri = $signed({ring_i[W-1], ring_i});
   assign ev = $signed({extr_v[W-1], extr_v});
   assign ei = $signed({extr_i[W-1], extr_i});

   assign vsum = tv + rv;
   assign isum = ti + ri;

   always_comb begin
      unique case (sel)
         SRC_TIP_V:  x = tv;
         SRC_RING_V: x = rv;
         SRC_LOOP_V: x = tv - rv;
         SRC_LONG_V: x = vsum >>> 1;
         SRC_LOOP_I: x = ti - ri;
         SRC_LONG_I: x = isum >>> 1;
         SRC_EXT_V:  x = ev;
         SRC_EXT_I:  x = ei;
         default:    x = '0;
      endcase
   end

   // magnitude, saturating the single value that does not fit in W bits
   assign mag  = x[XW-1] ? XW'(-x) : XW'(x);
   assign xabs = mag[W] ? {W{1'b1}} : mag[W-1:0];

endmodule

// File: rtl/ldiag_peak.sv
module ldiag_peak #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [W-1:0] mag,
   output logic [W-1:0] pk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pk <= '0;
      else if (clr)
         pk <= '0;
      else if (upd && (mag > pk))
         pk <= mag;
   end
endmodule

// File: rtl/ldiag_iir.sv
module ldiag_iir #(
   parameter int SW = 16,
   parameter int KW = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 upd,
   input  logic signed [SW-1:0] xin,
   input  logic [KW-1:0]        k,
   output logic signed [SW-1:0] y
);
   localparam int PW = SW + KW + 2;
   localparam logic signed [PW-1:0] YMAX = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
   localparam logic signed [PW-1:0] YMIN = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};

   logic signed [SW:0]   diff;
   logic signed [PW-1:0] prod, step, sum;
   logic signed [SW-1:0] ysat;

   assign diff = $signed({xin[SW-1], xin}) - $signed({y[SW-1], y});
   assign prod = PW'(diff) * PW'($signed({1'b0, k}));
   assign step = prod >>> KW;
   assign sum  = PW'(y) + step;

   always_comb begin
      if (sum > YMAX)
         ysat = {1'b0, {(SW-1){1'b1}}};
      else if (sum < YMIN)
         ysat = {1'b1, {(SW-1){1'b0}}};
      else
         ysat = sum[SW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         y <= '0;
      else if (flush)
         y <= '0;
      else if (upd)
         y <= ysat;
   end
endmodule

// File: rtl/line_diag_engine.sv
module line_diag_engine
   import line_diag_pkg::*;
#(
   parameter int W  = 8,
   parameter int SW = 16,
   parameter int KW = 15,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [W-1:0]  tip_v,
   input  logic [W-1:0]  ring_v,
   input  logic [W-1:0]  tip_i,
   input  logic [W-1:0]  ring_i,
   input  logic [W-1:0]  extr_v,
   input  logic [W-1:0]  extr_i,
   input  logic          hook_abort,
   input  logic          reg_wr,
   input  logic [2:0]    reg_waddr,
   input  logic [DW-1:0] reg_wdata,
   input  logic [2:0]    reg_raddr,
   output logic [DW-1:0] reg_rdata
);
   localparam int NFILT = 2;

   if (W < 2) begin : g_bad_w
      $error("line_diag_engine: W must be at least 2");
   end
   if (SW < W + 3) begin : g_bad_sw
      $error("line_diag_engine: SW must exceed W by at least 3");
   end
   if (KW < 1 || KW >= SW + 8) begin : g_bad_kw
      $error("line_diag_engine: KW out of range");
   end
   if (DW < SW || DW < KW || DW < 4) begin : g_bad_dw
      $error("line_diag_engine: DW too narrow for the readbacks");
   end

   logic        en_q;
   ldiag_src_e  sel_q;
   logic [KW-1:0] kq [NFILT];
   logic signed [SW-1:0] yq [NFILT];

   logic        wr_ctrl, flush, upd, pk_clr;
   ldiag_src_e  new_sel;
   logic signed [W:0] x;
   logic [W-1:0]      xabs;
   logic [W-1:0]      pk_q;

   assign wr_ctrl = reg_wr && (reg_waddr == A_CTRL);
   assign new_sel = ldiag_src_e'(reg_wdata[CTRL_SEL_LSB +: 3]);
   assign flush   = wr_ctrl && ((reg_wdata[CTRL_EN_BIT] && !en_q) || (new_sel != sel_q));
   assign upd     = en_q && smp_vld && !hook_abort && !flush;
   assign pk_clr  = reg_wr && (reg_waddr == A_PEAK) && (reg_wdata == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= SRC_TIP_V;
      end else begin
         if (hook_abort)
            en_q <= 1'b0;
         else if (wr_ctrl)
            en_q <= reg_wdata[CTRL_EN_BIT];
         if (wr_ctrl)
            sel_q <= new_sel;
      end
   end

   ldiag_src_sel #(.W(W)) src_i (
      .sel(sel_q), .tip_v(tip_v), .ring_v(ring_v), .tip_i(tip_i),
      .ring_i(ring_i), .extr_v(extr_v), .extr_i(extr_i),
      .x(x), .xabs(xabs)
   );

   ldiag_peak #(.W(W)) peak_i (
      .clk(clk), .rst_n(rst_n), .clr(flush || pk_clr), .upd(upd),
      .mag(xabs), .pk(pk_q)
   );

   // filter 0 is the DC path on the signed sample, filter 1 the rectified AC path
   for (genvar f = 0; f < NFILT; f++) begin : g_filt
      logic signed [SW-1:0] xin;
      logic [2:0]           kaddr;

      if (f == 0) begin : g_dc
         assign xin   = SW'(x);
         assign kaddr = A_KDC;
      end else begin : g_ac
         assign xin   = $signed(SW'(xabs));
         assign kaddr = A_KAC;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            kq[f] <= '0;
         else if (reg_wr && (reg_waddr == kaddr))
            kq[f] <= reg_wdata[KW-1:0];
      end

      ldiag_iir #(.SW(SW), .KW(KW)) iir_i (
         .clk(clk), .rst_n(rst_n), .flush(flush), .upd(upd),
         .xin(xin), .k(kq[f]), .y(yq[f])
      );
   end

   always_comb begin
      unique case (reg_raddr)
         A_CTRL:  reg_rdata = DW'({sel_q, en_q});
         A_KDC:   reg_rdata = DW'(kq[0]);
         A_KAC:   reg_rdata = DW'(kq[1]);
         A_PEAK:  reg_rdata = DW'(pk_q);
         A_DCOUT: reg_rdata = DW'(yq[0]);
         A_ACOUT: reg_rdata = DW'(yq[1]);
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ldiag_chk.sv
module ldiag_chk
   import line_diag_pkg::*;
#(
   parameter int W  = 8,
   parameter int SW = 16,
   parameter int DW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_vld,
   input logic                 hook_abort,
   input logic                 reg_wr,
   input logic [2:0]           reg_waddr,
   input logic [DW-1:0]        reg_wdata,
   input logic                 en_q,
   input logic [2:0]           sel_q,
   input logic [W-1:0]         pk_q,
   input logic signed [SW-1:0] dc_q,
   input logic signed [SW-1:0] ac_q
);
   logic ctl_wr, pk_wr;
   assign ctl_wr = reg_wr && (reg_waddr == A_CTRL);
   assign pk_wr  = reg_wr && (reg_waddr == A_PEAK);

   AST_ABORT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      hook_abort |=> !en_q);  // R8

   AST_PEAK_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_wr || pk_wr) |=> (pk_q >= $past(pk_q)));  // R3

   AST_AC_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      !ac_q[SW-1]);  // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !ctl_wr) |=> ($stable(dc_q) && $stable(ac_q)));  // R9

   AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !reg_wr) |=> ($stable(pk_q) && $stable(dc_q) && $stable(ac_q)));  // R9

   AST_SEL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && (reg_wdata[3:1] != sel_q)) |=> (pk_q == '0 && dc_q == '0 && ac_q == '0));  // R6

   AST_PEAK_ZERO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (pk_wr && reg_wdata == '0) |=> (pk_q == '0));  // R7

endmodule

bind line_diag_engine ldiag_chk #(.W(W), .SW(SW), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .hook_abort(hook_abort),
   .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
   .en_q(en_q), .sel_q(sel_q), .pk_q(pk_q), .dc_q(yq[0]), .ac_q(yq[1])
);

// File: tb/line_diag_engine_tb.sv
module line_diag_engine_tb_top;
   localparam int CLK_NS = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [7:0]  tip_v = '0, ring_v = '0, tip_i = '0, ring_i = '0, extr_v = '0, extr_i = '0;
   logic        hook_abort = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_waddr = '0;
   logic [15:0] reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [15:0] reg_rdata;

   int n_chk = 0;
   int n_bad = 0;

   // model state
   bit          m_en = 0;
   int          m_sel = 0;
   int          m_kdc = 0, m_kac = 0;
   int          m_pk = 0, m_dc = 0, m_ac = 0;

   always #(CLK_NS/2) clk = ~clk;

   line_diag_engine dut_i (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
      .tip_v(tip_v), .ring_v(ring_v), .tip_i(tip_i), .ring_i(ring_i),
      .extr_v(extr_v), .extr_i(extr_i), .hook_abort(hook_abort),
      .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
   );

   function automatic int sx(logic [7:0] v);
      return int'($signed(v));
   endfunction

   function automatic int src_val(int sel);
      case (sel)
         0: return sx(tip_v);
         1: return sx(ring_v);
         2: return sx(tip_v) - sx(ring_v);
         3: return (sx(tip_v) + sx(ring_v)) >>> 1;
         4: return sx(tip_i) - sx(ring_i);
         5: return (sx(tip_i) + sx(ring_i)) >>> 1;
         6: return sx(extr_v);
         default: return sx(extr_i);
      endcase
   endfunction

   function automatic int absat(int v);
      int a = (v < 0) ? -v : v;
      return (a > 255) ? 255 : a;
   endfunction

   function automatic int iir(int y, int x, int k);
      longint p = longint'(x - y) * longint'(k);
      longint s = longint'(y) + (p >>> 15);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return int'(s);
   endfunction

   task automatic cmp(string tag, int a, logic [15:0] exp);
      reg_raddr = 3'(a);
      #1;
      n_chk++;
      if (reg_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic check_all(string tag);
      cmp({tag, " R10 ctrl"}, 0, 16'({m_sel[2:0], m_en}));
      cmp({tag, " R10 kdc"}, 1, 16'(m_kdc));
      cmp({tag, " R10 kac"}, 2, 16'(m_kac));
      cmp({tag, " R3 peak"}, 3, 16'(m_pk));
      cmp({tag, " R4 dc"}, 4, 16'(m_dc));
      cmp({tag, " R5 ac"}, 5, 16'(m_ac));
      cmp({tag, " R10 unused"}, 6, 16'h0);
   endtask

   // one clock: drive, advance model, clock, release, check
   task automatic step(string tag, bit wr, int addr, logic [15:0] wd, bit vld, bit abt);
      bit ctrl, flush, proc, pclr;
      int x, xa;
      reg_wr = wr; reg_waddr = 3'(addr); reg_wdata = wd;
      smp_vld = vld; hook_abort = abt;
      ctrl  = wr && addr == 0;
      flush = ctrl && ((wd[0] && !m_en) || int'(wd[3:1]) != m_sel);
      proc  = m_en && vld && !abt && !flush;
      pclr  = wr && addr == 3 && wd == 16'h0;
      x  = src_val(m_sel);
      xa = absat(x);
      if (flush || pclr) m_pk = 0;
      else if (proc && xa > m_pk) m_pk = xa;
      if (flush) begin
         m_dc = 0; m_ac = 0;
      end else if (proc) begin
         m_dc = iir(m_dc, x, m_kdc);
         m_ac = iir(m_ac, xa, m_kac);
      end
      if (wr && addr == 1) m_kdc = int'(wd[14:0]);
      if (wr && addr == 2) m_kac = int'(wd[14:0]);
      if (abt) m_en = 0;
      else if (ctrl) m_en = wd[0];
      if (ctrl) m_sel = int'(wd[3:1]);
      @(posedge clk);
      @(negedge clk);
      reg_wr = 0; smp_vld = 0; hook_abort = 0;
      check_all(tag);
   endtask

   task automatic set_in(int tv, int rv, int ti, int ri, int ev, int ei);
      tip_v = 8'(tv); ring_v = 8'(rv); tip_i = 8'(ti);
      ring_i = 8'(ri); extr_v = 8'(ev); extr_i = 8'(ei);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");

      // coefficients
      step("R10 kdc write", 1, 1, 16'hC000, 0, 0);
      step("R10 kac write", 1, 2, 16'h2000, 0, 0);

      // enable on source 2, extreme loop difference
      set_in(127, -128, 0, 0, 0, 0);
      step("R6 enable rise", 1, 0, 16'h0005, 0, 0);
      step("R2 loop voltage max", 0, 0, 0, 1, 0);
      set_in(-128, 127, 0, 0, 0, 0);
      step("R2 loop voltage min", 0, 0, 0, 1, 0);

      // every source code once
      for (int s = 0; s < 8; s++) begin
         set_in(-128, -128, 100, -37, 77, -90);
         step("R2 source change", 1, 0, 16'(s * 2 + 1), 0, 0);
         step("R2 source sample", 0, 0, 0, 1, 0);
         set_in(-1, 0, -1, 0, -128, 127);
         step("R2 floor of half sum", 0, 0, 0, 1, 0);
      end

      // same control value rewritten: no flush
      set_in(50, 20, 0, 0, 0, 0);
      step("R6 setup", 1, 0, 16'h0001, 0, 0);
      step("R6 sample", 0, 0, 0, 1, 0);
      step("R6 same select no flush", 1, 0, 16'h0001, 0, 0);
      step("R6 flush beats sample", 1, 0, 16'h0003, 1, 0);

      // peak writes
      step("R7 sample", 0, 0, 0, 1, 0);
      step("R7 nonzero write ignored", 1, 3, 16'h0011, 0, 0);
      step("R7 zero write with sample", 1, 3, 16'h0000, 1, 0);
      step("R7 restart", 0, 0, 0, 1, 0);

      // abort with sample and with enabling write
      step("R8 abort blocks sample", 0, 0, 0, 1, 1);
      step("R9 disabled sample held", 0, 0, 0, 1, 0);
      step("R8 abort beats enable", 1, 0, 16'h0003, 0, 1);
      step("R6 re-enable", 1, 0, 16'h0003, 0, 0);
      step("R9 no strobe hold", 0, 0, 0, 0, 0);
      step("R4 max coef", 1, 1, 16'h7FFF, 0, 0);
      step("R5 max coef", 1, 2, 16'h7FFF, 0, 0);
      for (int i = 0; i < 6; i++) step("R4 converge", 0, 0, 0, 1, 0);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         int r;
         bit wr;
         int addr;
         logic [15:0] wd;
         set_in($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
         if ($urandom % 8 == 0) tip_v = 8'h80;
         if ($urandom % 8 == 0) ring_v = 8'h7F;
         r = $urandom % 256;
         wr = 0; addr = 0; wd = '0;
         if (r < 3) begin
            wr = 1; addr = 0;
            wd = 16'({3'($urandom), 1'($urandom % 8 != 0)});
         end else if (r < 5) begin
            wr = 1; addr = 3;
            wd = ($urandom % 2 == 0) ? 16'h0 : 16'($urandom);
         end else if (r < 7) begin
            wr = 1; addr = 1 + ($urandom % 2);
            wd = 16'($urandom);
         end
         step("R2 R3 R4 R5 random", wr, addr, wd,
              ($urandom % 3 == 0), ($urandom % 300 == 0));
      end

      summary();
      $finish;
   end
endmodule